// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed storage array and serves several requesters through one shared access path. Besides plain reads and writes it executes indivisible read-modify-write operations: compare-and-swap, test-and-set, fetch-and-increment and fetch-and-decrement. Every operation, including a plain read or write, runs as a fixed three-phase sequence: grant, read of the addressed word, then compute and an optional write. No other requester is admitted until that sequence completes. This fully serializes competing atomics, so of several identical compare-and-swap requests issued together exactly one succeeds.

A requester raises its valid line with an opcode, address, compare value and write value, and holds them until it sees its accept pulse. The accept pulse is combinational and marks the clock edge at which the request is taken. A round-robin arbiter chooses among the pending requesters. The unit answers the owning requester with a one-hot response strobe, the word's prior value and a success bit.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset no accept or response is signalled and every storage word reads as zero.
- R2: Opcode 0 (read) returns the stored word with success 1 and leaves it unchanged; opcodes 6 and 7 behave exactly like opcode 0.
- R3: Opcode 1 (write) stores the write value and returns the prior word with success 1.
- R4: Opcode 2 (compare-and-swap) stores the write value and reports success 1 when the prior word equals the compare value, returning the prior word.
- R5: When the prior word differs from the compare value, opcode 2 reports success 0, returns the prior word, leaves memory unchanged and takes the same number of cycles as a successful swap.
- R6: Opcode 3 (test-and-set) stores 1, returns the prior word and reports success 1 only when the prior word was 0.
- R7: Opcodes 4 (fetch-and-increment) and 5 (fetch-and-decrement) return the prior word and store it plus or minus one, wrapping modulo 2^DATA_W.
- R8: A request accepted in the cycle of its accept pulse gets its response exactly three cycles later, on its own bit of the one-hot response strobe, and no other request is accepted before that response.
- R9: Arbitration is round-robin: after requester i is granted, the search for the next grant starts at requester i+1 (wrapping), beginning at requester 0 after reset.
- R10: When every requester issues compare-and-swap with the same address, compare value and matching prior word at the same time, exactly one reports success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Per-requester request pending |
| req_op | input | 3*NUM_REQ | Per-requester opcode, 3 bits each |
| req_addr | input | ADDR_W*NUM_REQ | Per-requester word address |
| req_cmp | input | DATA_W*NUM_REQ | Per-requester compare value |
| req_wdata | input | DATA_W*NUM_REQ | Per-requester write value |
| req_accept | output | NUM_REQ | One-hot: request taken at the coming edge |
| rsp_valid | output | NUM_REQ | One-hot response strobe to the owner |
| rsp_rdata | output | DATA_W | Word value before the operation |
| rsp_ok | output | 1 | Success bit |

## Verification
Every result is due in the third cycle after the cycle in which its accept pulse is seen, so the bench stamps each scoreboard entry with that cycle number when the accept is observed and the monitor fails any response that arrives early, late or to the wrong requester. Expected prior values come from a reference array updated in acceptance order, which is the serialization order the unit promises. Inputs are driven just after a rising edge and accepts and responses are sampled on the falling edge, so the grant prediction for round-robin order and the single-winner count for simultaneous swaps read settled values.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_READ  = 3'd0;
    localparam logic [OP_W-1:0] OP_WRITE = 3'd1;
    localparam logic [OP_W-1:0] OP_CAS   = 3'd2;
    localparam logic [OP_W-1:0] OP_TAS   = 3'd3;
    localparam logic [OP_W-1:0] OP_INC   = 3'd4;
    localparam logic [OP_W-1:0] OP_DEC   = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } amu_state_e;

endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
    parameter int NUM_REQ = 3,
    localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt,
    output logic [IW-1:0]      gnt_idx
);

    logic [IW-1:0] ptr_q;
    logic          found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= NUM_REQ) j = j - NUM_REQ;
            if (!found && req[j]) begin
                found   = 1'b1;
                gnt[j]  = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (int'(gnt_idx) == NUM_REQ - 1) ? '0 : gnt_idx + IW'(1);
        end
    end

endmodule

// File: rtl/amu_regfile.sv
module amu_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/amu_alu.sv
module amu_alu
    import amu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic [DATA_W-1:0] new_val,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_val,
    output logic              ok
);

    always_comb begin
        wr_en  = 1'b0;
        wr_val = new_val;
        ok     = 1'b1;
        unique case (op)
            OP_WRITE: wr_en = 1'b1;
            OP_CAS: begin
                wr_en = (old_val == cmp_val);
                ok    = (old_val == cmp_val);
            end
            OP_TAS: begin
                wr_en  = 1'b1;
                wr_val = DATA_W'(1);
                ok     = (old_val == '0);
            end
            OP_INC: begin
                wr_en  = 1'b1;
                wr_val = old_val + DATA_W'(1);
            end
            OP_DEC: begin
                wr_en  = 1'b1;
                wr_val = old_val - DATA_W'(1);
            end
            default: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int NUM_REQ = 3,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*OP_W-1:0]   req_op,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_cmp,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        req_accept,
    output logic [NUM_REQ-1:0]        rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_ok
);

    logic [OP_W-1:0]   op_a    [NUM_REQ];
    logic [ADDR_W-1:0] addr_a  [NUM_REQ];
    logic [DATA_W-1:0] cmp_a   [NUM_REQ];
    logic [DATA_W-1:0] wdata_a [NUM_REQ];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_unpack
        assign op_a[g]    = req_op[g*OP_W +: OP_W];
        assign addr_a[g]  = req_addr[g*ADDR_W +: ADDR_W];
        assign cmp_a[g]   = req_cmp[g*DATA_W +: DATA_W];
        assign wdata_a[g] = req_wdata[g*DATA_W +: DATA_W];
    end

    amu_state_e        state_q;
    logic [NUM_REQ-1:0] owner_q;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] old_q;

    logic [NUM_REQ-1:0] arb_req;
    logic [NUM_REQ-1:0] gnt;
    logic [IW-1:0]      gnt_idx;

    assign arb_req    = (state_q == ST_IDLE) ? req_valid : '0;
    assign req_accept = gnt;

    amu_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (arb_req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    logic [DATA_W-1:0] rf_rdata;
    logic              alu_we;
    logic [DATA_W-1:0] alu_val;
    logic              alu_ok;
    logic              rf_we;

    assign rf_we = (state_q == ST_WRITE) && alu_we;

    amu_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr_q),
        .rd_data (rf_rdata),
        .we      (rf_we),
        .wr_data (alu_val)
    );

    amu_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .old_val (old_q),
        .cmp_val (cmp_q),
        .new_val (wdata_q),
        .wr_en   (alu_we),
        .wr_val  (alu_val),
        .ok      (alu_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            owner_q   <= '0;
            op_q      <= OP_READ;
            addr_q    <= '0;
            cmp_q     <= '0;
            wdata_q   <= '0;
            old_q     <= '0;
            rsp_valid <= '0;
            rsp_rdata <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (|gnt) begin
                        owner_q <= gnt;
                        op_q    <= op_a[gnt_idx];
                        addr_q  <= addr_a[gnt_idx];
                        cmp_q   <= cmp_a[gnt_idx];
                        wdata_q <= wdata_a[gnt_idx];
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    old_q   <= rf_rdata;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    rsp_valid <= owner_q;
                    rsp_rdata <= old_q;
                    rsp_ok    <= alu_ok;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
    parameter int NUM_REQ = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_accept,
    input logic [NUM_REQ-1:0] rsp_valid,
    input logic               mem_we
);

    a_r8_rsp_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));

    a_r8_accept_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_accept));

    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (|req_accept) |-> ##3 (rsp_valid == $past(req_accept, 3)));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (|req_accept) |=> (req_accept == '0) ##1 (req_accept == '0));

    a_r9_accept_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_accept & ~req_valid) == '0);

    // R5: storage changes only in the last phase, right before a response
    a_r5_write_then_rsp: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (rsp_valid != '0));

endmodule

bind atomic_mem_unit amu_checker #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .rsp_valid  (rsp_valid),
    .mem_we     (rf_we)
);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 3;
    localparam int DW   = 16;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NREQ-1:0]    req_valid;
    logic [NREQ*3-1:0]  req_op;
    logic [NREQ*AW-1:0] req_addr;
    logic [NREQ*DW-1:0] req_cmp;
    logic [NREQ*DW-1:0] req_wdata;
    logic [NREQ-1:0]    req_accept;
    logic [NREQ-1:0]    rsp_valid;
    logic [DW-1:0]      rsp_rdata;
    logic               rsp_ok;

    logic [2:0]    b_op    [NREQ];
    logic [AW-1:0] b_addr  [NREQ];
    logic [DW-1:0] b_cmp   [NREQ];
    logic [DW-1:0] b_wd    [NREQ];
    logic          b_valid [NREQ];
    int            b_rq    [NREQ];

    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            req_valid[i]           = b_valid[i];
            req_op[i*3 +: 3]       = b_op[i];
            req_addr[i*AW +: AW]   = b_addr[i];
            req_cmp[i*DW +: DW]    = b_cmp[i];
            req_wdata[i*DW +: DW]  = b_wd[i];
        end
    end

    atomic_mem_unit #(.NUM_REQ(NREQ), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_cmp(req_cmp), .req_wdata(req_wdata),
        .req_accept(req_accept), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
    );

    typedef struct {
        int          who;
        logic [DW-1:0] data;
        logic        ok;
        int          due;
        int          rq;
        logic        is_cas;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] model_mem [1 << AW];
    int            errors = 0;
    int            checks = 0;
    int            cyc = 0;
    int            rr_ptr = 0;
    int            cas_wins = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard: model update on accept, comparison on response
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid != '0) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected response act=%b exp=none", rsp_valid);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (rsp_valid != NREQ'(1 << e.who) || rsp_rdata !== e.data ||
                        rsp_ok !== e.ok || cyc != e.due) begin
                        errors++;
                        $display("FAIL R%0d act who=%b data=%h ok=%b cyc=%0d exp who=%0d data=%h ok=%b cyc=%0d",
                                 e.rq, rsp_valid, rsp_rdata, rsp_ok, cyc,
                                 e.who, e.data, e.ok, e.due);
                    end
                    if (e.is_cas && rsp_ok) cas_wins++;
                end
            end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
                checks++;
                errors++;
                $display("FAIL R8 missing response act=none exp=req%0d at cyc %0d",
                         sb_q[0].who, sb_q[0].due);
                void'(sb_q.pop_front());
            end

            if (req_accept != '0) begin
                int win;
                exp_t e;
                logic [DW-1:0] old;
                win = -1;
                for (int k = 0; k < NREQ; k++) begin
                    int j;
                    j = (rr_ptr + k) % NREQ;
                    if (win < 0 && req_valid[j]) win = j;
                end
                // R9: predicted round-robin winner
                checks++;
                if (win < 0 || req_accept != NREQ'(1 << win)) begin
                    errors++;
                    $display("FAIL R9 grant act=%b exp=req%0d", req_accept, win);
                end
                if (win >= 0) begin
                    rr_ptr = (win + 1) % NREQ;
                    old = model_mem[b_addr[win]];
                    e.who = win; e.data = old; e.ok = 1'b1;
                    e.due = cyc + 3; e.rq = b_rq[win]; e.is_cas = 1'b0;
                    case (b_op[win])
                        3'd1: model_mem[b_addr[win]] = b_wd[win];
                        3'd2: begin
                            e.is_cas = 1'b1;
                            e.ok = (old == b_cmp[win]);
                            if (e.ok) model_mem[b_addr[win]] = b_wd[win];
                        end
                        3'd3: begin
                            e.ok = (old == '0);
                            model_mem[b_addr[win]] = DW'(1);
                        end
                        3'd4: model_mem[b_addr[win]] = old + DW'(1);
                        3'd5: model_mem[b_addr[win]] = old - DW'(1);
                        default: ;
                    endcase
                    sb_q.push_back(e);
                end
            end
        end
    end

    task automatic drive(input int r, input logic [2:0] op, input int addr,
                         input logic [DW-1:0] cmp, input logic [DW-1:0] wd,
                         input int rq);
        @(posedge clk); #1;
        b_op[r] = op; b_addr[r] = AW'(addr); b_cmp[r] = cmp; b_wd[r] = wd;
        b_rq[r] = rq; b_valid[r] = 1'b1;
        forever begin
            @(negedge clk);
            if (req_accept[r]) break;
        end
        @(posedge clk); #1;
        b_valid[r] = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NREQ; i++) begin
            b_valid[i] = 1'b0; b_op[i] = '0; b_addr[i] = '0;
            b_cmp[i] = '0; b_wd[i] = '0; b_rq[i] = 0;
        end
        for (int i = 0; i < (1 << AW); i++) model_mem[i] = '0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: quiet outputs after reset
        checks++;
        if (rsp_valid !== '0 || req_accept !== '0) begin
            errors++;
            $display("FAIL R1 idle act=%b/%b exp=0/0", rsp_valid, req_accept);
        end
        // R1: words read as zero
        drive(0, 3'd0, 0, 0, 0, 1);
        drive(1, 3'd0, 5, 0, 0, 1);
        drive(2, 3'd0, 15, 0, 0, 1);

        // R3: writes return prior word
        drive(0, 3'd1, 3, 0, 16'h1234, 3);
        drive(1, 3'd1, 15, 0, 16'hBEEF, 3);
        drive(1, 3'd1, 15, 0, 16'h0F0F, 3);

        // R2: read and unused opcodes leave storage untouched
        drive(2, 3'd0, 3, 0, 16'hAAAA, 2);
        drive(2, 3'd7, 3, 0, 16'hAAAA, 2);
        drive(0, 3'd6, 3, 0, 16'hAAAA, 2);
        drive(1, 3'd0, 3, 0, 0, 2);

        // R4: matching compare-and-swap
        drive(0, 3'd2, 3, 16'h1234, 16'h5555, 4);
        drive(1, 3'd0, 3, 0, 0, 4);

        // R5: mismatching compare-and-swap, memory kept
        drive(2, 3'd2, 3, 16'h1234, 16'h9999, 5);
        drive(0, 3'd0, 3, 0, 0, 5);

        // R6: test-and-set on free then held lock
        drive(1, 3'd3, 8, 0, 0, 6);
        drive(2, 3'd3, 8, 0, 0, 6);
        drive(0, 3'd0, 8, 0, 0, 6);

        // R7: increment wrap at max, decrement wrap at zero
        drive(0, 3'd1, 9, 0, 16'hFFFF, 7);
        drive(1, 3'd4, 9, 0, 0, 7);
        drive(2, 3'd0, 9, 0, 0, 7);
        drive(0, 3'd5, 9, 0, 0, 7);
        drive(1, 3'd0, 9, 0, 0, 7);
        drive(2, 3'd4, 10, 0, 0, 7);
        drive(2, 3'd4, 10, 0, 0, 7);
        drive(0, 3'd5, 10, 0, 0, 7);
        drive(0, 3'd0, 10, 0, 0, 7);
        drain();

        // R10: identical concurrent compare-and-swap
        drive(0, 3'd1, 4, 0, 16'h0007, 10);
        drain();
        cas_wins = 0;
        fork
            drive(0, 3'd2, 4, 16'h0007, 16'h0020, 10);
            drive(1, 3'd2, 4, 16'h0007, 16'h0020, 10);
            drive(2, 3'd2, 4, 16'h0007, 16'h0020, 10);
        join
        drain();
        checks++;
        if (cas_wins != 1) begin
            errors++;
            $display("FAIL R10 winners act=%0d exp=1", cas_wins);
        end
        drive(1, 3'd0, 4, 0, 0, 10);

        // R9 and R8: all requesters stream back to back
        fork
            begin
                for (int n = 0; n < 4; n++) drive(0, 3'd4, 12, 0, 0, 9);
            end
            begin
                for (int n = 0; n < 4; n++) drive(1, 3'd0, 12, 0, 0, 8);
            end
            begin
                for (int n = 0; n < 4; n++) drive(2, 3'd5, 13, 0, 0, 9);
            end
        join
        drain();
        finish_run();
    end

endmodule